// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read engine on the memory side of a synchronous NOR-style flash device. A 16-bit configuration word, written through a simple strobe, selects these settings:

- whether clocked bursts are allowed at all
- how many clocks the first access takes
- the polarity of the WAIT pin and when it is raised
- whether each data word lasts one clock or two
- the order in which addresses are stepped
- whether a short burst wraps inside its group
- how many words a burst carries

A host places a word address on `addr` and pulls the active-low address strobe `adv_n`. Once the strobe is released, the block counts out the programmed latency. It then streams words from an internal array in the selected order, flagging each word with `dout_valid`.

When a burst steps across a 16-word row, the array needs one extra clock. The block inserts a gap cycle with no valid data and raises WAIT during that gap. If configured to do so, it also raises WAIT during the word that comes just before the gap. The array contents are loaded through a separate write port, which stands in for the array's programming path.

Top module: `sbr_burst_seq`

## Requirements
- R1: After synchronous reset, `dout_valid` is 0 and `wait_o` is 0. The configuration then holds these values:
  - asynchronous mode
  - latency code 2
  - WAIT active high
  - one-clock hold
  - WAIT on the crossing only
  - linear order
  - wrap on
  - 4-word length
- R2: Bit 15 of the configuration selects the read mode. With bit 15 at 1, address strobes start nothing and `dout_valid` stays 0. With bit 15 at 0, strobes start bursts.
- R3: Bits 13:11 hold the latency code, and only codes 2, 3, 4 and 5 are accepted. The first word is valid after the (code+2)-th rising edge at which `adv_n` is sampled high, counting from the edge that follows the last low sample. A write carrying code 0, 1, 6 or 7 leaves the previous code in place.
- R4: Bit 10 sets the WAIT polarity: 1 makes `wait_o` active high and 0 makes it active low.
- R5: Bit 9 sets the data hold: 0 keeps each word for one clock and 1 keeps it for two clocks.
- R6: Bits 2:0 set the burst length: 001 gives 4 words, 010 gives 8 words, and 111 gives a continuous burst that runs until the next strobe. Any other code leaves the previous length in place.
- R7: With bit 7 at 0 and a length of 4 or 8, beat b reads the group base of the start address, OR-ed with (start XOR b) masked to the group size. Bit 3 has no effect in this case.
- R8: With bit 7 at 1, bit 3 at 0 and a length of 4 or 8, beat b reads the group base OR-ed with (start + b) masked to the group size.
- R9: With bit 7 at 1 and bit 3 at 1, or with a continuous burst in either order, beat b reads (start + b) modulo the array size.
- R10: In the modes of R9, a word whose address has its low 4 bits at zero (other than the first word) is preceded by one cycle with `dout_valid` at 0 and WAIT active.
- R11: With bit 8 at 1, WAIT is also active during every hold cycle of the word that comes just before such a gap. With bit 8 at 0, WAIT is inactive on data words.
- R12: WAIT is inactive while no burst is running: when idle, during the latency count, and after the last word.
- R13: A strobe during a burst ends that burst: `dout_valid` is 0 after the first edge that samples `adv_n` low. A new burst then starts from the address present at the last edge with `adv_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| mem_we | input | 1 | Array load write enable |
| mem_waddr | input | AW | Array load address |
| mem_wdata | input | DW | Array load data |
| adv_n | input | 1 | Address strobe, active low |
| addr | input | AW | Burst start word address |
| dout | output | DW | Read data |
| dout_valid | output | 1 | Read data valid |
| wait_o | output | 1 | WAIT, polarity from configuration |

## Verification
Two events can meet in the same word. A two-clock data hold can coincide with the early WAIT for an upcoming row gap. A new address strobe can land on a gap cycle or in the middle of a held word. The bench provokes the first case with a linear non-wrapping burst that starts a few words below a row boundary, with hold and early WAIT both enabled. It provokes the second by restarting a continuous burst and by random configurations. Each case is judged cycle by cycle against a model that lays out the expected valid, data and WAIT level for every clock after the strobe.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  localparam int CFG_W     = 16;
  localparam int MODE_BIT  = 15;
  localparam int LAT_LSB   = 11;
  localparam int POL_BIT   = 10;
  localparam int HOLD_BIT  = 9;
  localparam int EARLY_BIT = 8;
  localparam int ORDER_BIT = 7;
  localparam int WRAP_BIT  = 3;
  localparam int LEN_LSB   = 0;

  typedef struct packed {
    logic       rm;      // 1: asynchronous mode, strobes ignored
    logic [2:0] lc;      // latency code
    logic       wpol;    // 1: WAIT active high
    logic       hold2;   // 1: two clocks per word
    logic       wearly;  // 1: WAIT also on word before a gap
    logic       lin;     // 1: linear order, 0: interleaved
    logic       nowrap;  // 1: linear bursts leave the group
    logic [2:0] blen;    // burst length code
  } sbr_cfg_t;

  // Per-burst settings captured at the strobe
  typedef struct packed {
    logic [2:0] lc;
    logic       hold2;
    logic       wearly;
    logic       lin;
    logic       nowrap;
    logic [2:0] blen;
  } sbr_run_t;

  typedef enum logic [1:0] {S_IDLE, S_LAT, S_DATA, S_GAP} sbr_state_e;

  localparam sbr_cfg_t CFG_RESET = '{rm: 1'b1, lc: 3'd2, wpol: 1'b1, hold2: 1'b0,
                                     wearly: 1'b0, lin: 1'b1, nowrap: 1'b0,
                                     blen: 3'b001};

  function automatic logic lat_code_ok(input logic [2:0] code);
    return (code >= 3'd2) && (code <= 3'd5);
  endfunction

  function automatic logic len_code_ok(input logic [2:0] code);
    return (code == 3'b001) || (code == 3'b010) || (code == 3'b111);
  endfunction

  function automatic sbr_run_t run_of(input sbr_cfg_t c);
    return '{lc: c.lc, hold2: c.hold2, wearly: c.wearly, lin: c.lin,
             nowrap: c.nowrap, blen: c.blen};
  endfunction

endpackage

// File: rtl/sbr_cfg_reg.sv
module sbr_cfg_reg
  import sbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output sbr_cfg_t         cfg
);

  logic [2:0] lat_in;
  logic [2:0] len_in;
  logic       wdata_unused;

  assign lat_in       = wdata[LAT_LSB +: 3];
  assign len_in       = wdata[LEN_LSB +: 3];
  assign wdata_unused = ^{wdata[14], wdata[6:4]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
    end else if (we) begin
      cfg.rm     <= wdata[MODE_BIT];
      cfg.wpol   <= wdata[POL_BIT];
      cfg.hold2  <= wdata[HOLD_BIT];
      cfg.wearly <= wdata[EARLY_BIT];
      cfg.lin    <= wdata[ORDER_BIT];
      cfg.nowrap <= wdata[WRAP_BIT];
      if (lat_code_ok(lat_in)) cfg.lc   <= lat_in;
      if (len_code_ok(len_in)) cfg.blen <= len_in;
    end
  end

  // R3: a reserved latency code leaves the field unchanged
  p_lat_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (we && !lat_code_ok(lat_in)) |=> $stable(cfg.lc));

  // R6: a reserved length code leaves the field unchanged
  p_len_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (we && !len_code_ok(len_in)) |=> $stable(cfg.blen));

endmodule

// File: rtl/sbr_addr_gen.sv
module sbr_addr_gen #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] beat,
  input  logic          lin,
  input  logic          nowrap,
  input  logic          cont,
  input  logic          big,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] mask;
  logic [AW-1:0] base;
  logic [AW-1:0] lin_a;

  always_comb begin
    mask  = big ? AW'(7) : AW'(3);
    base  = start & ~mask;
    lin_a = start + beat;
    if (cont || (lin && nowrap)) addr = lin_a;
    else if (lin)                addr = base | (lin_a & mask);
    else                         addr = base | ((start ^ beat) & mask);
  end

endmodule

// File: rtl/sbr_array.sv
module sbr_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/sbr_burst_seq.sv
module sbr_burst_seq
  import sbr_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int ROW_BITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             mem_we,
  input  logic [AW-1:0]    mem_waddr,
  input  logic [DW-1:0]    mem_wdata,
  input  logic             adv_n,
  input  logic [AW-1:0]    addr,
  output logic [DW-1:0]    dout,
  output logic             dout_valid,
  output logic             wait_o
);

  sbr_cfg_t      cfg;
  sbr_run_t      rc;
  sbr_state_e    state, st_n;
  logic [AW-1:0] start_q, start_n;
  logic [AW-1:0] beat, beat_n, beat_p1, bb;
  logic [3:0]    lat_cnt, lat_n, n_lat;
  logic          hold_q, hold_n, valid_n, wact_q, wact_n, rd_en;
  logic          cont, big, unwrapped, last_bb, cross_in, early;
  logic [AW-1:0] run_len;
  logic [AW-1:0] ag_addr [2];
  logic          strobe;

  sbr_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  assign strobe = !cfg.rm && !adv_n;

  // Burst settings are frozen at the strobe
  always_ff @(posedge clk) begin
    if (rst)         rc <= run_of(CFG_RESET);
    else if (strobe) rc <= run_of(cfg);
  end

  assign cont      = (rc.blen == 3'b111);
  assign big       = (rc.blen == 3'b010);
  assign run_len   = big ? AW'(8) : AW'(4);
  assign unwrapped = cont || (rc.lin && rc.nowrap);
  assign n_lat     = {1'b0, rc.lc} + 4'd2;
  assign beat_p1   = beat + AW'(1);
  assign bb        = (state == S_DATA) ? beat_p1 :
                     (state == S_GAP)  ? beat    : '0;
  assign last_bb   = !cont && ((bb + AW'(1)) == run_len);

  // Address of the beat to show next and of the one after it
  for (genvar g = 0; g < 2; g++) begin : g_ag
    sbr_addr_gen #(.AW(AW)) u_ag (
      .start  (start_q),
      .beat   (bb + AW'(g)),
      .lin    (rc.lin),
      .nowrap (rc.nowrap),
      .cont   (cont),
      .big    (big),
      .addr   (ag_addr[g])
    );
  end

  assign cross_in = unwrapped && (bb != '0) && (ag_addr[0][ROW_BITS-1:0] == '0);
  assign early    = rc.wearly && unwrapped && !last_bb &&
                    (ag_addr[1][ROW_BITS-1:0] == '0);

  sbr_array #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (rd_en),
    .raddr (ag_addr[0]),
    .rdata (dout)
  );

  always_comb begin
    st_n    = state;
    start_n = start_q;
    beat_n  = beat;
    lat_n   = lat_cnt;
    hold_n  = hold_q;
    valid_n = dout_valid;
    wact_n  = wact_q;
    rd_en   = 1'b0;
    if (cfg.rm) begin
      st_n    = S_IDLE;
      valid_n = 1'b0;
      wact_n  = 1'b0;
    end else if (!adv_n) begin
      st_n    = S_LAT;
      start_n = addr;
      lat_n   = '0;
      valid_n = 1'b0;
      wact_n  = 1'b0;
    end else begin
      case (state)
        S_LAT: begin
          lat_n = lat_cnt + 4'd1;
          if ((lat_cnt + 4'd1) >= n_lat) begin
            rd_en   = 1'b1;
            st_n    = S_DATA;
            beat_n  = '0;
            hold_n  = 1'b0;
            valid_n = 1'b1;
            wact_n  = early;
          end
        end
        S_DATA: begin
          if (rc.hold2 && !hold_q) begin
            hold_n = 1'b1;
          end else if (!cont && (beat_p1 == run_len)) begin
            st_n    = S_IDLE;
            valid_n = 1'b0;
            wact_n  = 1'b0;
          end else if (cross_in) begin
            st_n    = S_GAP;
            beat_n  = bb;
            valid_n = 1'b0;
            wact_n  = 1'b1;
          end else begin
            rd_en   = 1'b1;
            beat_n  = bb;
            hold_n  = 1'b0;
            valid_n = 1'b1;
            wact_n  = early;
          end
        end
        S_GAP: begin
          rd_en   = 1'b1;
          st_n    = S_DATA;
          hold_n  = 1'b0;
          valid_n = 1'b1;
          wact_n  = early;
        end
        default: begin
          valid_n = 1'b0;
          wact_n  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      start_q    <= '0;
      beat       <= '0;
      lat_cnt    <= '0;
      hold_q     <= 1'b0;
      dout_valid <= 1'b0;
      wact_q     <= 1'b0;
      wait_o     <= ~CFG_RESET.wpol;
    end else begin
      state      <= st_n;
      start_q    <= start_n;
      beat       <= beat_n;
      lat_cnt    <= lat_n;
      hold_q     <= hold_n;
      dout_valid <= valid_n;
      wact_q     <= wact_n;
      wait_o     <= cfg.wpol ? wact_n : ~wact_n;
    end
  end

  // R2: asynchronous mode produces no burst data
  p_async_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    cfg.rm |=> !dout_valid);

  // R5: first half of a two-clock word is followed by the same word
  p_hold_twice_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_DATA && rc.hold2 && !hold_q && adv_n && !cfg.rm)
      |=> (dout_valid && $stable(dout)));

  // R6: a bounded burst never runs past its length
  p_len_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_DATA && !cont) |-> (beat < run_len));

  // R10: a gap cycle is always followed by data
  p_gap_resume_r10: assert property (@(posedge clk) disable iff (rst)
    (state == S_GAP && adv_n && !cfg.rm) |=> dout_valid);

  // R12: WAIT sits at its inactive level while idle
  p_idle_wait_r12: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && $stable(cfg.wpol)) |-> (wait_o == ~cfg.wpol));

  // R13: a strobe ends any burst on the next edge
  p_restart_r13: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (!dout_valid && state == S_LAT));

endmodule

// File: tb/tb_sbr_burst_seq.sv
module tb_sbr_burst_seq;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic          mem_we = 1'b0;
  logic [AW-1:0] mem_waddr = '0;
  logic [DW-1:0] mem_wdata = '0;
  logic          adv_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dout;
  logic          dout_valid;
  logic          wait_o;

  int n_tests = 0;
  int n_fail  = 0;

  // bench copy of the configuration, following the requirements
  bit       bm_rm = 1'b1, bm_pol = 1'b1, bm_hold = 1'b0, bm_early = 1'b0;
  bit       bm_lin = 1'b1, bm_nowrap = 1'b0;
  bit [2:0] bm_lc = 3'd2, bm_blen = 3'b001;

  bit          ev [0:127];
  bit          ew [0:127];
  bit [DW-1:0] ed [0:127];

  always #2.5 clk = ~clk;

  sbr_burst_seq #(.AW(AW), .DW(DW)) dut (
    .clk, .rst, .cfg_we, .cfg_wdata, .mem_we, .mem_waddr, .mem_wdata,
    .adv_n, .addr, .dout, .dout_valid, .wait_o
  );

  function automatic bit [DW-1:0] mdata(input int a);
    return DW'((a * 929) ^ 16'hC3A5);
  endfunction

  function automatic bit [15:0] mk_cfg(input bit rm, input bit [2:0] lc, input bit pol,
      input bit hold, input bit early, input bit lin, input bit nowrap, input bit [2:0] bl);
    return {rm, 1'b0, lc, pol, hold, early, lin, 1'b1, 2'b00, nowrap, bl};
  endfunction

  function automatic bit [AW-1:0] exp_addr(input bit [AW-1:0] s, input int b);
    bit [AW-1:0] m, bw;
    bw = AW'(b);
    m  = (bm_blen == 3'b010) ? AW'(7) : AW'(3);
    if (bm_blen == 3'b111 || (bm_lin && bm_nowrap)) return s + bw;
    if (bm_lin) return (s & ~m) | ((s + bw) & m);
    return (s & ~m) | ((s ^ bw) & m);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input bit [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    bm_rm = v[15]; bm_pol = v[10]; bm_hold = v[9]; bm_early = v[8];
    bm_lin = v[7]; bm_nowrap = v[3];
    if (v[13:11] >= 3'd2 && v[13:11] <= 3'd5) bm_lc = v[13:11];
    if (v[2:0] == 3'b001 || v[2:0] == 3'b010 || v[2:0] == 3'b111) bm_blen = v[2:0];
  endtask

  task automatic build_expect(input bit [AW-1:0] s, input int ncyc);
    int c, b, len;
    bit cont, unw, nx;
    bit [AW-1:0] a, an;
    for (int i = 0; i < 128; i++) begin ev[i] = 0; ew[i] = 0; ed[i] = '0; end
    if (bm_rm) return;
    cont = (bm_blen == 3'b111);
    len  = (bm_blen == 3'b010) ? 8 : 4;
    unw  = cont || (bm_lin && bm_nowrap);
    c = int'(bm_lc) + 2;
    b = 0;
    while (c <= ncyc) begin
      if (!cont && b == len) break;
      a = exp_addr(s, b);
      if (b > 0 && unw && a[3:0] == 4'd0) begin
        ew[c] = 1'b1;
        c++;
      end
      an = exp_addr(s, b + 1);
      nx = (cont || (b + 1 < len)) && unw && (an[3:0] == 4'd0);
      for (int h = 0; h < (bm_hold ? 2 : 1); h++) begin
        if (c <= ncyc) begin
          ev[c] = 1'b1; ed[c] = mdata(int'(a)); ew[c] = bm_early && nx;
        end
        c++;
      end
      b++;
    end
  endtask

  task automatic run_burst(input bit [AW-1:0] s, input int ncyc, input string tag);
    build_expect(s, ncyc);
    @(negedge clk);
    adv_n = 1'b0; addr = s;
    @(negedge clk);
    adv_n = 1'b1;
    for (int c = 1; c <= ncyc; c++) begin
      @(negedge clk);
      chk(dout_valid == ev[c], tag, $sformatf("valid cycle %0d", c), dout_valid, ev[c]);
      if (ev[c])
        chk(dout == ed[c], tag, $sformatf("data cycle %0d", c), dout, ed[c]);
      chk(wait_o == (ew[c] ? bm_pol : !bm_pol), tag, $sformatf("wait cycle %0d", c),
          wait_o, ew[c] ? bm_pol : !bm_pol);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(dout_valid == 1'b0, "R1", "reset valid", dout_valid, 0);
    chk(wait_o == 1'b0, "R1", "reset wait", wait_o, 0);

    for (int i = 0; i < (1 << AW); i++) begin
      @(negedge clk);
      mem_we = 1'b1; mem_waddr = AW'(i); mem_wdata = mdata(i);
    end
    @(negedge clk);
    mem_we = 1'b0;

    // R1 R2: reset leaves asynchronous mode, strobe ignored
    run_burst(8'h05, 16, "R1 R2 async after reset");

    // R3 R8: latency 2, linear wrap, 4 words
    write_cfg(mk_cfg(0, 3'd2, 1, 0, 0, 1, 0, 3'b001));
    run_burst(8'h05, 14, "R3 R8 R12");
    // R3 R7: latency 5, interleaved, 8 words
    write_cfg(mk_cfg(0, 3'd5, 1, 0, 0, 0, 0, 3'b010));
    run_burst(8'h2D, 20, "R3 R7");
    // R7: wrap bit has no effect on interleaved order
    write_cfg(mk_cfg(0, 3'd3, 1, 0, 0, 0, 1, 3'b001));
    run_burst(8'h4E, 14, "R7 wrap ignored");
    // R3: reserved latency code keeps previous code 3
    write_cfg(mk_cfg(0, 3'd6, 1, 0, 0, 1, 0, 3'b010));
    run_burst(8'h13, 18, "R3 reserved code");
    // R6: reserved length code keeps previous 8 words
    write_cfg(mk_cfg(0, 3'd4, 1, 0, 0, 1, 0, 3'b011));
    run_burst(8'h6B, 18, "R6 reserved length");
    // R5: two-clock hold
    write_cfg(mk_cfg(0, 3'd2, 1, 1, 0, 1, 0, 3'b001));
    run_burst(8'h91, 16, "R5 hold");
    // R4: active-low WAIT, idle level high
    write_cfg(mk_cfg(0, 3'd2, 0, 0, 0, 1, 1, 3'b010));
    repeat (2) @(negedge clk);
    chk(wait_o == 1'b1, "R4", "idle wait active low", wait_o, 1);
    run_burst(8'h0C, 18, "R4 R9 R10");
    // R9 R10: unwrapped linear, crossing, WAIT on crossing only
    write_cfg(mk_cfg(0, 3'd3, 1, 0, 0, 1, 1, 3'b010));
    run_burst(8'h1B, 20, "R9 R10");
    // R11 with R5: early WAIT during a two-clock word
    write_cfg(mk_cfg(0, 3'd2, 1, 1, 1, 1, 1, 3'b010));
    run_burst(8'h3D, 26, "R11 R5");
    // R6 R9 R10 R11: continuous burst past the array end
    write_cfg(mk_cfg(0, 3'd4, 1, 0, 1, 0, 0, 3'b111));
    run_burst(8'hFA, 40, "R6 R9 R10 R11 continuous");
    // R13: restart during a burst, last low address wins
    run_burst(8'h30, 12, "R13 first burst");
    @(negedge clk);
    adv_n = 1'b0; addr = 8'h77;
    @(negedge clk);
    chk(dout_valid == 1'b0, "R13", "valid after strobe", dout_valid, 0);
    run_burst(8'h41, 24, "R13 restarted");
    // R2: back to asynchronous mode
    write_cfg(mk_cfg(1, 3'd2, 1, 0, 0, 1, 0, 3'b001));
    run_burst(8'h22, 16, "R2 async");

    // random configurations
    for (int k = 0; k < 40; k++) begin
      bit [2:0] bl;
      int sel;
      sel = int'($urandom_range(0, 2));
      bl  = (sel == 0) ? 3'b001 : (sel == 1) ? 3'b010 : 3'b111;
      write_cfg(mk_cfg(0, 3'($urandom_range(2, 5)), 1'($urandom_range(0, 1)),
                       1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                       1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), bl));
      run_burst(8'($urandom_range(0, 255)), 36, "R3 R5 R6 R7 R8 R9 R10 R11 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule